// File: doc/BRIEF.md
# Hot-Plug Slot Command Controller

This block executes software commands against a bank of hot-plug slots. Software writes a command dword; one byte lane carries the command code and the next lane carries the logical slot target. Any write that enables either of those two lanes starts a command. The controller checks the command against the present slot states. It then updates the per-slot state, indicator, latch-open, presence and event-latch fields. It reports the outcome in a four-bit command status word and raises a one-cycle done pulse for the interrupt logic.

There are three command classes. A single-slot command changes one slot. A bus speed command accepts only the base speed. An all-slot command either powers every slot or enables every slot. An all-slot command first scans every slot, one slot per clock. If any slot is already enabled, nothing changes. Otherwise a second pass updates each slot in turn. While the sequencer runs, the busy bit is high and further command writes are dropped. A combinational read port exposes any slot's record. The slot count is a parameter from 1 to 31. At reset, each slot is populated from an occupancy input.

Top module: `hp_slot_cmd_ctrl`

## Requirements
- R1: During reset each slot with `slot_occupied[i]=1` becomes enabled (state 2), power LED on (1), latch closed, presence 0. A slot with `slot_occupied[i]=0` becomes disabled (3), power LED off (3), latch open, presence 3. Attention LED and events become 0. Status, bus speed and `cmd_detected` become 0.
- R2: A write with `wr_addr`=5 and `wr_be[0]` or `wr_be[1]` set starts a command. Lane 0 (`wr_data[7:0]`) loads the code. Lane 1 bits `wr_data[12:8]` load the target. A lane that is not enabled keeps its previous value. Writes to any other address start nothing. Status bits [3:0] are cleared at the start. For every command except an all-slot command, the results and a one-cycle `cmd_detected` pulse appear in the cycle after the write edge.
- R3: Codes 0x00–0x3F are single-slot commands. Code[1:0] is the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled). Code[3:2] is the power LED and code[5:4] is the attention LED (0 keep, 1 on, 2 blink, 3 off). A field of 0 leaves the slot field unchanged.
- R4: A target of 0 or above NSLOTS sets the invalid-command bit (status bit 2) and changes no slot. Target t selects slot t-1.
- R5: Requesting power-only for an enabled slot sets status bit 2 and leaves the slot, LEDs included, unchanged.
- R6: A disabled slot takes a requested power-only or enabled state. An enabled or power-only slot takes a requested disabled state. Every other request keeps the state.
- R7: When a slot becomes disabled and its power LED, after the LED update, reads off, the slot shows latch open and presence 3. It also sets all three event bits (`rd_events` bit 0 presence, bit 1 button, bit 2 latch).
- R8: Codes 0x40–0x47 request bus speed code[2:0]. Speed 0 is accepted. Any other speed sets the invalid-mode bit (status bit 3) and leaves `bus_speed` at 0.
- R9: Code 0x48 (power all) and code 0x49 (enable all) scan the slots from index 0. If slot k is enabled, the command fails after k+1 busy cycles, sets status bit 2 and changes no slot. Otherwise, after 2·NSLOTS busy cycles, each latch-closed slot has received the requested state under R6 with its power LED on. Each latch-open slot keeps its state with its power LED off.
- R10: While status bit 0 (busy) is high, command writes are ignored completely.
- R11: Any other code sets status bit 2. `cmd_detected` pulses once after every command, failed or not. For an all-slot command it pulses in the cycle in which busy falls.
- R12: The read port returns the record of `rd_slot` combinationally. For an index at or beyond NSLOTS it returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Dword index of the write |
| wr_be | input | 2 | Byte lane enables (lane 0 code, lane 1 target) |
| wr_data | input | 16 | Write data for lanes 0 and 1 |
| slot_occupied | input | NSLOTS | Slot population applied during reset |
| rd_slot | input | 5 | Slot index for the read port |
| rd_state | output | 2 | Slot state of the read slot |
| rd_pwr_led | output | 2 | Power LED of the read slot |
| rd_attn_led | output | 2 | Attention LED of the read slot |
| rd_mrl_open | output | 1 | Retention latch open flag of the read slot |
| rd_presence | output | 2 | Presence code of the read slot |
| rd_events | output | 3 | Latched events of the read slot |
| cmd_status | output | 4 | {invalid mode, invalid command, latch open, busy} |
| bus_speed | output | 3 | Current secondary bus speed |
| cmd_detected | output | 1 | One-cycle pulse when a command completes |

## Verification
The assertions watch the slot write path on every cycle. No slot write may move an enabled slot to power-only. A write that opens a latch must also mark the slot empty and set all its events. Busy must exclude every error bit, and every falling edge of busy must coincide with the done pulse. The bus speed must never leave the base value. The reference model in the bench is the only check on the outcomes that depend on a sequence of commands. These outcomes are the exact busy lengths for a failed scan and a successful one, the per-slot results after an all-slot pass, the dropped write during busy, and the byte-lane merge of code and target.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int TGT_W = 5;
    localparam logic [5:0] CMD_DWORD = 6'd5;

    typedef logic [TGT_W-1:0] sidx_t;

    typedef enum logic [1:0] {
        ST_KEEP     = 2'd0,
        ST_PWRONLY  = 2'd1,
        ST_ENABLED  = 2'd2,
        ST_DISABLED = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        LED_KEEP  = 2'd0,
        LED_ON    = 2'd1,
        LED_BLINK = 2'd2,
        LED_OFF   = 2'd3
    } led_e;

    localparam logic [1:0] PRES_LOW   = 2'd0;
    localparam logic [1:0] PRES_EMPTY = 2'd3;
    // event bits: [0] presence, [1] button, [2] latch
    localparam logic [2:0] EV_REMOVE  = 3'b111;

    typedef struct packed {
        slot_state_e state;
        led_e        pwr;
        led_e        attn;
        logic        mrl_open;
        logic [1:0]  presence;
        logic [2:0]  events;
    } slot_rec_t;

    typedef enum logic [1:0] {
        K_SLOT,
        K_SPEED,
        K_ALL,
        K_BAD
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e   kind;
        slot_state_e req;
        led_e        pwr;
        led_e        attn;
        logic        all_enable;
        logic [2:0]  speed;
    } cmd_dec_t;

    // enabled -> power-only is the one forbidden move
    function automatic logic slot_illegal(slot_state_e cur, slot_state_e req);
        return (cur == ST_ENABLED) && (req == ST_PWRONLY);
    endfunction

    function automatic slot_rec_t slot_apply(slot_rec_t cur, slot_state_e req,
                                             led_e pwr, led_e attn);
        slot_rec_t nxt;
        nxt = cur;
        if (pwr != LED_KEEP) nxt.pwr = pwr;
        if (attn != LED_KEEP) nxt.attn = attn;
        if (cur.state == ST_DISABLED &&
            (req == ST_PWRONLY || req == ST_ENABLED)) begin
            nxt.state = req;
        end else if ((cur.state == ST_ENABLED || cur.state == ST_PWRONLY) &&
                     req == ST_DISABLED) begin
            nxt.state = ST_DISABLED;
            if (nxt.pwr == LED_OFF) begin
                nxt.mrl_open = 1'b1;
                nxt.presence = PRES_EMPTY;
                nxt.events   = nxt.events | EV_REMOVE;
            end
        end
        return nxt;
    endfunction

    function automatic slot_rec_t slot_reset(logic occupied);
        slot_rec_t r;
        r.attn   = LED_KEEP;
        r.events = 3'b000;
        if (occupied) begin
            r.state    = ST_ENABLED;
            r.pwr      = LED_ON;
            r.mrl_open = 1'b0;
            r.presence = PRES_LOW;
        end else begin
            r.state    = ST_DISABLED;
            r.pwr      = LED_OFF;
            r.mrl_open = 1'b1;
            r.presence = PRES_EMPTY;
        end
        return r;
    endfunction

endpackage

// File: rtl/hpc_cmd_decode.sv
module hpc_cmd_decode
    import hpc_pkg::*;
(
    input  logic [7:0] code,
    output cmd_dec_t   dec
);

    always_comb begin
        dec.req        = slot_state_e'(code[1:0]);
        dec.pwr        = led_e'(code[3:2]);
        dec.attn       = led_e'(code[5:4]);
        dec.all_enable = code[0];
        dec.speed      = code[2:0];
        if (code[7:6] == 2'b00) begin
            dec.kind = K_SLOT;
        end else if (code[7:3] == 5'b01000) begin
            dec.kind = K_SPEED;
        end else if (code == 8'h48 || code == 8'h49) begin
            dec.kind = K_ALL;
        end else begin
            dec.kind = K_BAD;
        end
    end

endmodule

// File: rtl/hpc_slot_bank.sv
module hpc_slot_bank
    import hpc_pkg::*;
#(
    parameter int NSLOTS = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSLOTS-1:0] occupied,
    input  logic              we,
    input  sidx_t             widx,
    input  slot_rec_t         wdata,
    input  sidx_t             ra_idx,
    output slot_rec_t         ra_data,
    input  sidx_t             rb_idx,
    output slot_rec_t         rb_data
);

    slot_rec_t slot_q [NSLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOTS; i++) begin
                slot_q[i] <= slot_reset(occupied[i]);
            end
        end else if (we) begin
            for (int i = 0; i < NSLOTS; i++) begin
                if (widx == sidx_t'(i)) slot_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        ra_data = '0;
        rb_data = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (ra_idx == sidx_t'(i)) ra_data = slot_q[i];
            if (rb_idx == sidx_t'(i)) rb_data = slot_q[i];
        end
    end

endmodule

// File: rtl/hpc_all_seq.sv
module hpc_all_seq
    import hpc_pkg::*;
#(
    parameter int NSLOTS = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  slot_state_e cur_state,
    output sidx_t       idx,
    output logic        busy,
    output logic        apply_we,
    output logic        done_ok,
    output logic        done_fail
);

    localparam sidx_t LAST_IDX = sidx_t'(NSLOTS - 1);

    typedef enum logic [1:0] {SQ_IDLE, SQ_SCAN, SQ_APPLY} seq_e;

    seq_e  st_q;
    sidx_t idx_q;

    assign idx       = idx_q;
    assign busy      = (st_q != SQ_IDLE);
    assign apply_we  = (st_q == SQ_APPLY);
    assign done_fail = (st_q == SQ_SCAN) && (cur_state == ST_ENABLED);
    assign done_ok   = (st_q == SQ_APPLY) && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        st_q  <= SQ_SCAN;
                        idx_q <= '0;
                    end
                end
                SQ_SCAN: begin
                    if (cur_state == ST_ENABLED) begin
                        st_q  <= SQ_IDLE;
                        idx_q <= '0;
                    end else if (idx_q == LAST_IDX) begin
                        st_q  <= SQ_APPLY;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + sidx_t'(1);
                    end
                end
                SQ_APPLY: begin
                    if (idx_q == LAST_IDX) begin
                        st_q  <= SQ_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + sidx_t'(1);
                    end
                end
                default: begin
                    st_q  <= SQ_IDLE;
                    idx_q <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hp_slot_cmd_ctrl.sv
module hp_slot_cmd_ctrl
    import hpc_pkg::*;
#(
    parameter int NSLOTS = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [1:0]        wr_be,
    input  logic [15:0]       wr_data,
    input  logic [NSLOTS-1:0] slot_occupied,
    input  logic [4:0]        rd_slot,
    output logic [1:0]        rd_state,
    output logic [1:0]        rd_pwr_led,
    output logic [1:0]        rd_attn_led,
    output logic              rd_mrl_open,
    output logic [1:0]        rd_presence,
    output logic [2:0]        rd_events,
    output logic [3:0]        cmd_status,
    output logic [2:0]        bus_speed,
    output logic              cmd_detected
);

    // command registers and their byte-lane merge
    logic [7:0] code_q;
    sidx_t      tgt_q;
    logic [7:0] nxt_code;
    sidx_t      nxt_tgt;
    logic       trigger;
    logic       unused_hi;

    // sequencer handshake
    logic  seq_busy;
    logic  seq_apply;
    logic  seq_ok;
    logic  seq_fail;
    sidx_t seq_idx;
    logic  all_en_q;

    // slot bank access
    cmd_dec_t    dec;
    sidx_t       slot_idx;
    logic        tgt_ok;
    logic        illegal;
    slot_rec_t   cur_rec;
    slot_rec_t   bank_wdata;
    slot_rec_t   rd_rec;
    logic        bank_we;
    slot_state_e all_req;
    led_e        all_pwr;

    // status flops
    logic       inv_cmd_q;
    logic       inv_mode_q;
    logic       det_q;
    logic [2:0] speed_q;

    assign unused_hi = ^wr_data[15:13];

    assign trigger  = wr_en && (wr_addr == CMD_DWORD) && (|wr_be) && !seq_busy;
    assign nxt_code = wr_be[0] ? wr_data[7:0] : code_q;
    assign nxt_tgt  = wr_be[1] ? wr_data[12:8] : tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            tgt_q  <= '0;
        end else if (trigger) begin
            code_q <= nxt_code;
            tgt_q  <= nxt_tgt;
        end
    end

    hpc_cmd_decode u_dec (
        .code (nxt_code),
        .dec  (dec)
    );

    assign tgt_ok   = (nxt_tgt != '0) && (int'(nxt_tgt) <= NSLOTS);
    assign slot_idx = seq_busy ? seq_idx : (nxt_tgt - sidx_t'(1));
    assign illegal  = slot_illegal(cur_rec.state, dec.req);

    // all-slot pass: closed latch takes the request, open latch turns LED off
    assign all_req = cur_rec.mrl_open ? ST_KEEP :
                     (all_en_q ? ST_ENABLED : ST_PWRONLY);
    assign all_pwr = cur_rec.mrl_open ? LED_OFF : LED_ON;

    always_comb begin
        if (seq_busy) begin
            bank_we    = seq_apply;
            bank_wdata = slot_apply(cur_rec, all_req, all_pwr, LED_KEEP);
        end else begin
            bank_we    = trigger && (dec.kind == K_SLOT) && tgt_ok && !illegal;
            bank_wdata = slot_apply(cur_rec, dec.req, dec.pwr, dec.attn);
        end
    end

    hpc_slot_bank #(.NSLOTS(NSLOTS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .occupied (slot_occupied),
        .we       (bank_we),
        .widx     (slot_idx),
        .wdata    (bank_wdata),
        .ra_idx   (slot_idx),
        .ra_data  (cur_rec),
        .rb_idx   (rd_slot),
        .rb_data  (rd_rec)
    );

    hpc_all_seq #(.NSLOTS(NSLOTS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (trigger && (dec.kind == K_ALL)),
        .cur_state (cur_rec.state),
        .idx       (seq_idx),
        .busy      (seq_busy),
        .apply_we  (seq_apply),
        .done_ok   (seq_ok),
        .done_fail (seq_fail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_cmd_q  <= 1'b0;
            inv_mode_q <= 1'b0;
            det_q      <= 1'b0;
            speed_q    <= '0;
            all_en_q   <= 1'b0;
        end else begin
            det_q <= (trigger && dec.kind != K_ALL) || seq_ok || seq_fail;
            if (trigger) begin
                inv_cmd_q  <= (dec.kind == K_BAD) ||
                              ((dec.kind == K_SLOT) && (!tgt_ok || illegal));
                inv_mode_q <= (dec.kind == K_SPEED) && (dec.speed != 3'd0);
                all_en_q   <= dec.all_enable;
                if (dec.kind == K_SPEED && dec.speed == 3'd0) speed_q <= dec.speed;
            end else if (seq_fail) begin
                inv_cmd_q <= 1'b1;
            end
        end
    end

    assign cmd_status   = {inv_mode_q, inv_cmd_q, 1'b0, seq_busy};
    assign bus_speed    = speed_q;
    assign cmd_detected = det_q;

    assign rd_state    = rd_rec.state;
    assign rd_pwr_led  = rd_rec.pwr;
    assign rd_attn_led = rd_rec.attn;
    assign rd_mrl_open = rd_rec.mrl_open;
    assign rd_presence = rd_rec.presence;
    assign rd_events   = rd_rec.events;

endmodule

// File: rtl/hpc_cmd_checker.sv
module hpc_cmd_checker
    import hpc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_status,
    input logic       cmd_detected,
    input logic [2:0] bus_speed,
    input logic       bank_we,
    input slot_rec_t  bank_cur,
    input slot_rec_t  bank_wdata
);

    logic unused_chk;
    assign unused_chk = ^{bank_cur, bank_wdata};

    a_r5_no_enabled_to_pwronly: assert property (@(posedge clk) disable iff (rst)
        bank_we && bank_cur.state == ST_ENABLED |-> bank_wdata.state != ST_PWRONLY);

    a_r7_open_means_empty: assert property (@(posedge clk) disable iff (rst)
        bank_we && bank_wdata.mrl_open && !bank_cur.mrl_open
        |-> bank_wdata.presence == PRES_EMPTY && bank_wdata.events == EV_REMOVE);

    a_r8_speed_stays_base: assert property (@(posedge clk) disable iff (rst)
        bus_speed == 3'd0);

    a_r9_busy_no_errors: assert property (@(posedge clk) disable iff (rst)
        cmd_status[0] |-> cmd_status[3:1] == 3'b000);

    a_r11_done_on_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_status[0]) |-> cmd_detected);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_detected |-> !cmd_status[0]);

endmodule

bind hp_slot_cmd_ctrl hpc_cmd_checker u_hpc_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_status   (cmd_status),
    .cmd_detected (cmd_detected),
    .bus_speed    (bus_speed),
    .bank_we      (bank_we),
    .bank_cur     (cur_rec),
    .bank_wdata   (bank_wdata)
);

// File: tb/test_hp_slot_cmd_ctrl.sv
module test_hp_slot_cmd_ctrl;

    localparam int N = 6;
    localparam logic [N-1:0] OCC = 6'b000101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_slot = '0;
    logic [1:0]  rd_state, rd_pwr_led, rd_attn_led, rd_presence;
    logic        rd_mrl_open;
    logic [2:0]  rd_events;
    logic [3:0]  cmd_status;
    logic [2:0]  bus_speed;
    logic        cmd_detected;

    always #4 clk = ~clk; // 8 ns period, 125 MHz

    hp_slot_cmd_ctrl #(.NSLOTS(N)) i_hp_slot_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .slot_occupied(OCC), .rd_slot(rd_slot),
        .rd_state(rd_state), .rd_pwr_led(rd_pwr_led), .rd_attn_led(rd_attn_led),
        .rd_mrl_open(rd_mrl_open), .rd_presence(rd_presence), .rd_events(rd_events),
        .cmd_status(cmd_status), .bus_speed(bus_speed), .cmd_detected(cmd_detected)
    );

    // reference model state
    int m_state[N], m_pwr[N], m_attn[N], m_mrl[N], m_pres[N], m_ev[N];
    int m_code, m_tgt, m_inv, m_mode, m_rem, m_det, m_fail, m_en;
    int vectors = 0, miscompares = 0, cycles = 0;
    bit chk_on = 1'b0;
    string tag = "R1";

    function automatic void m_init();
        for (int i = 0; i < N; i++) begin
            m_state[i] = OCC[i] ? 2 : 3;
            m_pwr[i]   = OCC[i] ? 1 : 3;
            m_mrl[i]   = OCC[i] ? 0 : 1;
            m_pres[i]  = OCC[i] ? 0 : 3;
            m_attn[i]  = 0;
            m_ev[i]    = 0;
        end
        m_code = 0; m_tgt = 0; m_inv = 0; m_mode = 0; m_rem = 0; m_det = 0;
        m_fail = 0; m_en = 0;
    endfunction

    // returns 1 when the request is refused
    function automatic int m_slot(int i, int req, int pwr, int attn);
        if (m_state[i] == 2 && req == 1) return 1;
        if (pwr != 0) m_pwr[i] = pwr;
        if (attn != 0) m_attn[i] = attn;
        if (m_state[i] == 3 && (req == 1 || req == 2)) begin
            m_state[i] = req;
        end else if ((m_state[i] == 2 || m_state[i] == 1) && req == 3) begin
            m_state[i] = 3;
            if (m_pwr[i] == 3) begin
                m_mrl[i] = 1; m_pres[i] = 3; m_ev[i] = 7;
            end
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_init();
        end else begin
            int busy_pre;
            int k;
            int dummy;
            busy_pre = (m_rem > 0);
            m_det = 0;
            if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_det = 1;
                    if (m_fail != 0) m_inv = 1;
                    else begin
                        for (int i = 0; i < N; i++) begin
                            if (m_mrl[i] == 0) dummy = m_slot(i, (m_en != 0) ? 2 : 1, 1, 0);
                            else dummy = m_slot(i, 0, 3, 0);
                        end
                    end
                end
            end
            if (wr_en && wr_addr == 6'd5 && wr_be != 2'b00 && busy_pre == 0) begin
                if (wr_be[0]) m_code = wr_data[7:0];
                if (wr_be[1]) m_tgt = wr_data[12:8];
                m_inv = 0; m_mode = 0;
                if (m_code < 'h40) begin
                    m_det = 1;
                    if (m_tgt == 0 || m_tgt > N) m_inv = 1;
                    else m_inv = m_slot(m_tgt - 1, m_code & 3, (m_code >> 2) & 3,
                                        (m_code >> 4) & 3);
                end else if (m_code < 'h48) begin
                    m_det = 1;
                    if ((m_code & 7) != 0) m_mode = 1;
                end else if (m_code == 'h48 || m_code == 'h49) begin
                    k = -1;
                    for (int i = N - 1; i >= 0; i--) if (m_state[i] == 2) k = i;
                    m_en = (m_code == 'h49);
                    if (k >= 0) begin m_rem = k + 1; m_fail = 1; end
                    else begin m_rem = 2 * N; m_fail = 0; end
                end else begin
                    m_det = 1;
                    m_inv = 1;
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            check("status", cmd_status, {m_mode[0], m_inv[0], 1'b0, m_rem > 0});
            check("detected", cmd_detected, m_det);
            check("bus speed", bus_speed, 0);
            if (m_rem == 0) begin
                if (rd_slot < N) begin
                    check("slot state", rd_state, m_state[rd_slot]);
                    check("power led", rd_pwr_led, m_pwr[rd_slot]);
                    check("attn led", rd_attn_led, m_attn[rd_slot]);
                    check("latch open", rd_mrl_open, m_mrl[rd_slot]);
                    check("presence", rd_presence, m_pres[rd_slot]);
                    check("events", rd_events, m_ev[rd_slot]);
                end else begin
                    // R12: index beyond the bank reads as zero
                    check("R12 empty read", {rd_state, rd_pwr_led, rd_attn_led,
                          rd_mrl_open, rd_presence, rd_events}, 0);
                end
            end
            rd_slot = (rd_slot == 5'(N)) ? 5'd0 : rd_slot + 5'd1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [5:0] a, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    task automatic cmd(logic [7:0] code, logic [4:0] tgt);
        wr(6'd5, 2'b11, {3'b000, tgt, code});
    endtask

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        chk_on = 1'b1;
        tag = "R1"; idle(2 * (N + 1));              // reset population of all slots
        tag = "R3"; cmd(8'h26, 5'd2); idle(N + 1);  // R6: disabled -> enabled, LEDs set
        tag = "R5"; cmd(8'h11, 5'd1); idle(N + 1);  // enabled -> power-only refused
        tag = "R4"; cmd(8'h02, 5'd0); idle(2);
        cmd(8'h02, 5'd7); idle(N + 1);
        tag = "R7"; cmd(8'h0F, 5'd3); idle(N + 1);  // disable with LED off -> removal
        tag = "R6"; cmd(8'h0B, 5'd1); idle(N + 1);  // disable with blink: no removal
        tag = "R8"; cmd(8'h40, 5'd0); idle(2);
        cmd(8'h43, 5'd0); idle(2);
        tag = "R11"; cmd(8'h80, 5'd0); idle(2);
        cmd(8'h4A, 5'd0); idle(2);
        tag = "R2"; wr(6'd6, 2'b11, 16'h0103); idle(3); // other address: no command
        tag = "R9"; cmd(8'h48, 5'd0); idle(N + 4);  // slot 1 enabled: fails after 2 cycles
        tag = "R6"; cmd(8'h03, 5'd2); idle(N + 1);  // disable with LED on
        tag = "R10"; cmd(8'h49, 5'd0); cmd(8'h48, 5'd0); idle(2 * N + 4); // second write dropped
        tag = "R9"; idle(N + 1);
        cmd(8'h48, 5'd0); idle(N + 2);              // slot 0 now enabled: fails at once
        tag = "R2"; wr(6'd5, 2'b01, 16'h0030); idle(2); // keeps target 0: invalid
        wr(6'd5, 2'b10, 16'h0600); idle(N + 1);     // keeps code 0x30 on target 6
        tag = "R5"; cmd(8'h01, 5'd1); idle(N + 2);
        chk_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule